// File: doc/BRIEF.md
# Accumulator Arithmetic Status Flag Register

This block pairs a 16-bit accumulator with a small adder and an 8-bit status register. An operation strobe applies add, add-with-carry, subtract, subtract-with-borrow or compare to the accumulator and an operand. The result goes into the accumulator, and the carry, overflow and equals flags are updated under fixed rules for each operation.

The zero and sign flags are not stored. They are read-only views of the accumulator. Software can write the five writable flag bits through a write port, and it can load the accumulator directly. Both the status byte and the accumulator are always visible on read outputs. All state changes take effect on the rising clock edge after the inputs are presented. Reset is synchronous and active high.

Top module: `acc_flag_unit`

## Requirements
- R1: While reset is held, the following clock edge leaves the accumulator at 0000h and the status byte at 80h.
- R2: Status bit 7 is 1 exactly when the accumulator is zero. Writes to this bit have no effect.
- R3: Status bit 6 equals accumulator bit 15. Writes to this bit have no effect.
- R4: Status bit 5 always reads 0 and ignores writes.
- R5: Opcodes are 0 for add, 1 for add with carry (the current carry flag is added), 2 for subtract, 3 for subtract with borrow (the current carry flag is subtracted) and 4 for compare. Codes 5 to 7 change nothing. An arithmetic result is written to the accumulator on the edge after the strobe.
- R6: Compare sets bit 0 when the operand equals the accumulator and clears it otherwise. Compare leaves the accumulator, bit 1 and bit 2 untouched. The four arithmetic operations leave bit 0 untouched.
- R7: Arithmetic operations set bit 1 on a carry out of bit 15 for add, or on a borrow for subtract, and clear it otherwise. Subtraction is computed as A + ~B + carry-in, and the borrow is the inverse of the carry out.
- R8: Arithmetic operations set bit 2 when exactly one of the carry out of bit 14 and the carry out of bit 15 occurs, and clear it otherwise.
- R9: A register write stores data bits 4..0 into bits 4 (general flag 1), 3 (general flag 0), 2, 1 and 0.
- R10: When a register write and a flag-updating operation fall in the same cycle, the operation's value wins for the bits that operation affects. The other written bits still take the written value.
- R11: An accumulator load stores its data on the next edge, unless an arithmetic operation is strobed in the same cycle, in which case the arithmetic result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select |
| opOperand | input | 16 | Second operand |
| accLoad | input | 1 | Accumulator load strobe |
| accLoadData | input | 16 | Accumulator load value |
| regWrite | input | 1 | Status write strobe |
| regWriteData | input | 8 | Status write value |
| statusOut | output | 8 | Status byte |
| accOut | output | 16 | Accumulator value |

## Verification
A status write can fall in the same cycle as an arithmetic or compare strobe, and an accumulator load can fall in the same cycle as an arithmetic strobe. Directed cases drive each pair together with values chosen so that the written and the computed flag values differ. Seeded random stimulus then sets the three strobes independently, so these collisions recur many times. Each cycle the status byte and the accumulator are compared with a bench model that applies the write, then the load, then the operation. Under that order the operation's bits override the written ones.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int STAT_W = 8;
  localparam int SOFT_W = 5;

  localparam int BIT_E   = 0;
  localparam int BIT_C   = 1;
  localparam int BIT_OV  = 2;
  localparam int BIT_G0  = 3;
  localparam int BIT_G1  = 4;
  localparam int BIT_RSV = 5;
  localparam int BIT_S   = 6;
  localparam int BIT_Z   = 7;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDC = 3'd1;
  localparam logic [2:0] OP_SUB  = 3'd2;
  localparam logic [2:0] OP_SUBB = 3'd3;
  localparam logic [2:0] OP_CMP  = 3'd4;

  typedef struct packed {
    logic arithUpd;
    logic cmpUpd;
    logic invertOperand;
    logic carryIn;
    logic borrowSense;
  } ctrlStrobes_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic         carryFlag,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (opValid) begin
      unique case (opCode)
        OP_ADD: begin
          strobes.arithUpd = 1'b1;
        end
        OP_ADDC: begin
          strobes.arithUpd = 1'b1;
          strobes.carryIn  = carryFlag;
        end
        OP_SUB: begin
          strobes.arithUpd      = 1'b1;
          strobes.invertOperand = 1'b1;
          strobes.carryIn       = 1'b1;
          strobes.borrowSense   = 1'b1;
        end
        OP_SUBB: begin
          strobes.arithUpd      = 1'b1;
          strobes.invertOperand = 1'b1;
          strobes.carryIn       = ~carryFlag;
          strobes.borrowSense   = 1'b1;
        end
        OP_CMP: begin
          strobes.cmpUpd = 1'b1;
        end
        default: strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ACC_W-1:0]  opOperand,
  input  logic              accLoad,
  input  logic [ACC_W-1:0]  accLoadData,
  input  logic              regWrite,
  input  logic [STAT_W-1:0] regWriteData,
  output logic [STAT_W-1:0] statusOut,
  output logic [ACC_W-1:0]  accOut,
  output logic              carryFlag
);
  logic [ACC_W-1:0]  accReg;
  logic [SOFT_W-1:0] softFlags;
  logic [ACC_W-1:0]  opEff;
  logic [ACC_W-1:0]  sumBits;
  logic [ACC_W:0]    carryChain;
  logic              carryTop;
  logic              carryBelowTop;
  logic              operandEqual;
  logic [ACC_W-1:0]  accNext;
  logic [SOFT_W-1:0] flagsNext;

  assign opEff         = strobes.invertOperand ? ~opOperand : opOperand;
  assign carryChain[0] = strobes.carryIn;

  for (genvar i = 0; i < ACC_W; i++) begin : g_ripple
    assign sumBits[i]      = accReg[i] ^ opEff[i] ^ carryChain[i];
    assign carryChain[i+1] = (accReg[i] & opEff[i]) |
                             (accReg[i] & carryChain[i]) |
                             (opEff[i] & carryChain[i]);
  end

  assign carryTop      = carryChain[ACC_W];
  assign carryBelowTop = carryChain[ACC_W-1];
  assign operandEqual  = (opOperand == accReg);

  always_comb begin
    accNext   = accReg;
    flagsNext = softFlags;
    if (regWrite) flagsNext = regWriteData[SOFT_W-1:0];
    if (accLoad)  accNext   = accLoadData;
    if (strobes.arithUpd) begin
      accNext          = sumBits;
      flagsNext[BIT_C]  = carryTop ^ strobes.borrowSense;
      flagsNext[BIT_OV] = carryTop ^ carryBelowTop;
    end
    if (strobes.cmpUpd) flagsNext[BIT_E] = operandEqual;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg    <= '0;
      softFlags <= '0;
    end else begin
      accReg    <= accNext;
      softFlags <= flagsNext;
    end
  end

  assign carryFlag = softFlags[BIT_C];
  assign accOut    = accReg;
  assign statusOut = {(accReg == '0), accReg[ACC_W-1], 1'b0, softFlags};
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import flag_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ACC_W-1:0]  opOperand,
  input  logic              accLoad,
  input  logic [ACC_W-1:0]  accLoadData,
  input  logic              regWrite,
  input  logic [STAT_W-1:0] regWriteData,
  output logic [STAT_W-1:0] statusOut,
  output logic [ACC_W-1:0]  accOut
);
  ctrlStrobes_t strobes;
  logic         carryFlag;

  flag_ctrl u_ctrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .carryFlag(carryFlag),
    .strobes  (strobes)
  );

  flag_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .opOperand   (opOperand),
    .accLoad     (accLoad),
    .accLoadData (accLoadData),
    .regWrite    (regWrite),
    .regWriteData(regWriteData),
    .statusOut   (statusOut),
    .accOut      (accOut),
    .carryFlag   (carryFlag)
  );
endmodule

// File: rtl/flag_checker.sv
module flag_checker
  import flag_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [ACC_W-1:0]  opOperand,
  input logic              accLoad,
  input logic [ACC_W-1:0]  accLoadData,
  input logic              regWrite,
  input logic [STAT_W-1:0] regWriteData,
  input logic [STAT_W-1:0] statusOut,
  input logic [ACC_W-1:0]  accOut
);
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (statusOut == 8'h80 && accOut == '0));

  a_r6_cmp_equals: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_CMP) |=>
      (statusOut[BIT_E] == ($past(opOperand) == $past(accOut))));

  a_r6_cmp_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_CMP && !accLoad && !regWrite) |=>
      ($stable(accOut) && $stable(statusOut[BIT_OV:BIT_C])));

  a_r7_add_carry: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_ADD) |=>
      (statusOut[BIT_C] ==
       (({1'b0, $past(accOut)} + {1'b0, $past(opOperand)}) > {1'b0, {ACC_W{1'b1}}})));

  a_r8_add_overflow: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_ADD) |=>
      (statusOut[BIT_OV] ==
       (($past(accOut[ACC_W-1]) == $past(opOperand[ACC_W-1])) &&
        (accOut[ACC_W-1] != $past(accOut[ACC_W-1])))));

  a_r9_soft_write: assert property (@(posedge clk) disable iff (rst)
    (regWrite && !opValid) |=>
      (statusOut[SOFT_W-1:0] == $past(regWriteData[SOFT_W-1:0])));

  a_r11_acc_load: assert property (@(posedge clk) disable iff (rst)
    (accLoad && !opValid) |=> (accOut == $past(accLoadData)));
endmodule

bind acc_flag_unit flag_checker #(.ACC_W(ACC_W)) u_flag_checker (
  .clk         (clk),
  .rst         (rst),
  .opValid     (opValid),
  .opCode      (opCode),
  .opOperand   (opOperand),
  .accLoad     (accLoad),
  .accLoadData (accLoadData),
  .regWrite    (regWrite),
  .regWriteData(regWriteData),
  .statusOut   (statusOut),
  .accOut      (accOut)
);

// File: tb/test_acc_flag_unit.sv
module test_acc_flag_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [2:0]  opCode;
  logic [15:0] opOperand;
  logic        accLoad;
  logic [15:0] accLoadData;
  logic        regWrite;
  logic [7:0]  regWriteData;
  logic [7:0]  statusOut;
  logic [15:0] accOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [15:0] mAcc;
  logic [4:0]  mFlags;

  always #10 clk = ~clk;

  acc_flag_unit i_acc_flag_unit (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opOperand(opOperand), .accLoad(accLoad), .accLoadData(accLoadData),
    .regWrite(regWrite), .regWriteData(regWriteData),
    .statusOut(statusOut), .accOut(accOut)
  );

  function automatic logic [7:0] expStatus(logic [15:0] a, logic [4:0] f);
    return {(a == 16'h0000), a[15], 1'b0, f};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 50000", cycles);
      summary();
    end
  end

  task automatic modelStep();
    logic [15:0] b;
    logic        cin;
    logic [16:0] s;
    logic [15:0] lo;
    logic        c15, c14;
    logic [15:0] oldAcc;
    oldAcc = mAcc;
    if (regWrite) mFlags = regWriteData[4:0];
    if (accLoad)  mAcc   = accLoadData;
    if (opValid && opCode <= 3'd3) begin
      b   = opCode[1] ? ~opOperand : opOperand;
      cin = (opCode == 3'd0) ? 1'b0 : (opCode == 3'd1) ? mFlags[1] :
            (opCode == 3'd2) ? 1'b1 : ~mFlags[1];
      // the carry in reads the flag held before this edge, so a write in the same cycle does not feed it
      if (opCode == 3'd1) cin = i_carryBefore;
      if (opCode == 3'd3) cin = ~i_carryBefore;
      s   = {1'b0, oldAcc} + {1'b0, b} + {16'b0, cin};
      lo  = {1'b0, oldAcc[14:0]} + {1'b0, b[14:0]} + {15'b0, cin};
      c15 = s[16];
      c14 = lo[15];
      mAcc      = s[15:0];
      mFlags[1] = opCode[1] ? ~c15 : c15;
      mFlags[2] = c14 ^ c15;
    end
    if (opValid && opCode == 3'd4) mFlags[0] = (opOperand == oldAcc);
  endtask

  logic i_carryBefore;

  task automatic cycleCheck(string req);
    i_carryBefore = mFlags[1];
    modelStep();
    @(negedge clk);
    checks++;
    if (statusOut !== expStatus(mAcc, mFlags) || accOut !== mAcc) begin
      fails++;
      $display("FAIL %s: actual status %h acc %h, expected status %h acc %h",
               req, statusOut, accOut, expStatus(mAcc, mFlags), mAcc);
    end
    opValid = 0; accLoad = 0; regWrite = 0;
  endtask

  task automatic op(logic [2:0] code, logic [15:0] v, string req);
    opValid = 1; opCode = code; opOperand = v;
    cycleCheck(req);
  endtask

  task automatic load(logic [15:0] v, string req);
    accLoad = 1; accLoadData = v;
    cycleCheck(req);
  endtask

  task automatic wr(logic [7:0] v, string req);
    regWrite = 1; regWriteData = v;
    cycleCheck(req);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; opValid = 0; opCode = 0; opOperand = 0;
    accLoad = 0; accLoadData = 0; regWrite = 0; regWriteData = 0;
    mAcc = 16'hFFFF; mFlags = 5'h1F;
    @(negedge clk); @(negedge clk);
    rst = 0;
    mAcc = 0; mFlags = 0;
    checks++;
    if (statusOut !== 8'h80 || accOut !== 16'h0) begin
      fails++;
      $display("FAIL R1: actual status %h acc %h, expected status 80 acc 0000", statusOut, accOut);
    end

    wr(8'hFF, "R2 R3 R4 R9 write all ones");
    wr(8'h00, "R9 clear");
    load(16'h7FFF, "R11 load");
    op(3'd0, 16'h0001, "R8 R3 signed overflow on add");
    op(3'd0, 16'h8000, "R7 R2 carry out to zero");
    op(3'd1, 16'h0005, "R5 add with carry");
    load(16'h0000, "R11 load zero");
    op(3'd2, 16'h0001, "R7 borrow on subtract");
    op(3'd3, 16'h0001, "R5 subtract with borrow");
    load(16'h8000, "R11 load min");
    op(3'd2, 16'h0001, "R8 overflow on subtract");
    op(3'd4, 16'h7FFF, "R6 compare equal");
    op(3'd4, 16'h1234, "R6 compare unequal");
    op(3'd5, 16'h1111, "R5 unused code ignored");
    op(3'd7, 16'h2222, "R5 unused code ignored");
    op(3'd0, 16'h0001, "R6 add keeps equals");
    regWrite = 1; regWriteData = 8'h1F;
    op(3'd0, 16'h0000, "R10 write with add collision");
    regWrite = 1; regWriteData = 8'h00;
    op(3'd4, accOut, "R10 write with compare collision");
    accLoad = 1; accLoadData = 16'hABCD;
    op(3'd0, 16'h0001, "R11 load with add collision");
    accLoad = 1; accLoadData = 16'h4444;
    op(3'd4, 16'h4444, "R11 load with compare");

    for (int n = 0; n < 2000; n++) begin
      opValid      = ($urandom % 3) != 0;
      opCode       = 3'($urandom % 6);
      opOperand    = ($urandom % 8 == 0) ? accOut : 16'($urandom);
      if ($urandom % 10 == 0) opOperand = 16'h8000;
      accLoad      = ($urandom % 4) == 0;
      accLoadData  = ($urandom % 6 == 0) ? 16'h0000 : 16'($urandom);
      regWrite     = ($urandom % 4) == 0;
      regWriteData = 8'($urandom);
      cycleCheck("R5 R6 R7 R8 R9 R10 R11 random");
    end

    rst = 1;
    @(negedge clk);
    rst = 0;
    checks++;
    if (statusOut !== 8'h80 || accOut !== 16'h0) begin
      fails++;
      $display("FAIL R1: actual status %h acc %h, expected status 80 acc 0000", statusOut, accOut);
    end
    summary();
  end
endmodule